// File: doc/BRIEF.md
# Conversion Slot Flag and Result Register Unit

This block keeps the completion state of an analog-to-digital conversion sequence. An external sequencer presents a done strobe together with the position of the finished conversion inside the sequence (its slot) and the converted value. Each slot owns one flag bit, one result register, one compare-enable bit and one operator bit. A slot in normal mode stores the value and raises its flag. A slot in compare mode treats its result register as a threshold. It raises its flag only when the comparison holds, and the converted value is dropped.

Software reaches the unit through a small synchronous register bus. It programs modes, reads and clears flags, reads results or loads thresholds, and starts a new sequence, which wipes every flag. Flags can be cleared in three ways, chosen by a fast-clear mode bit and the slot's compare mode. The order of precedence between a clear and a flag set that arrive in the same cycle is fixed. A single compare interrupt request line reports any raised compare-mode flag.

Top module: `conv_flag_unit`

## Requirements
- R1: A done strobe with slot index n, in a slot whose compare-enable bit is 0, sets flag bit n and loads result register n with the value. Both are visible one clock later. Flag n depends only on the slot index, with no other mapping.
- R2: In a slot whose compare-enable bit is 1, a done strobe never changes result register n. That register keeps the threshold written by software.
- R3: In compare mode, flag n is set only when the comparison is true. Operator bit n = 1 tests value > threshold (strictly). Operator bit n = 0 tests value <= threshold.
- R4: `cmp_irq` is high exactly when the interrupt-enable bit is 1 and at least one flag of a compare-mode slot is 1. It stays high until those flags are cleared.
- R5: Any write to the start address (0x04) clears all flags on the next edge. This clear takes priority over a flag set in the same cycle.
- R6: With fast-clear off, writing the flag register (0x00) clears each flag whose data bit is 1 and leaves the flags at 0 bits unchanged. A read of a result register then clears nothing.
- R7: With fast-clear on, reading result register n of a normal-mode slot clears flag n. Writes to the flag register then have no effect.
- R8: With fast-clear on, writing result register n of a compare-mode slot clears flag n and loads the new threshold.
- R9: When a write-one clear, a fast-clear read or a fast-clear write meets a set of the same flag in the same cycle, the flag ends up set.
- R10: The synchronous active-low reset clears all flags, results, compare-enable bits, operator bits and mode bits. Reads have no side effect other than the one in R7.
- R11: The address map is as follows. 0x00 holds the flags (bit n = slot n). 0x01 is control: bit 0 is fast-clear and bit 1 is interrupt-enable. 0x02 holds the compare-enable bits and 0x03 the operator bits, with bit n for slot n. 0x04 is start, and reads as 0. Result n is at 0x10+n and reads back zero-extended. Read data is combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a conversion finished |
| conv_slot | input | 4 | Sequence position of the finished conversion |
| conv_value | input | 10 | Converted value |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
Flag and result updates take effect at the edge that samples the strobe or bus write. They are due one cycle later. Read data is combinational, so the bench checks it shortly after driving the address, before the edge that may apply a read-triggered clear. `cmp_irq` follows registered state with no extra delay. A behavioural model is updated at each rising edge and compared at each falling edge. Same-cycle collisions of set with each clear source are driven deliberately, so that the priority order is exercised.

// File: rtl/cfu_pkg.sv
// Package: shared constants and types for the conversion flag unit.
// Assumes result registers occupy the upper half of the address space.
package cfu_pkg;

    localparam int CTRL_FAST_BIT = 0;
    localparam int CTRL_IEN_BIT  = 1;

    localparam logic [2:0] ADDR_FLAGS = 3'd0;
    localparam logic [2:0] ADDR_CTRL  = 3'd1;
    localparam logic [2:0] ADDR_CMPEN = 3'd2;
    localparam logic [2:0] ADDR_OPGT  = 3'd3;
    localparam logic [2:0] ADDR_START = 3'd4;

    typedef struct packed {
        logic irq_en;
        logic fast_clr;
    } cfu_ctrl_t;

endpackage

// File: rtl/cfu_bus_decode.sv
// Module: turns one bus access into per-register strobes.
// Assumes addresses with MSB=1 select result register addr[SLOT_W-1:0],
// and addresses with MSB=0 select control registers by their low bits.
module cfu_bus_decode #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic                 wr_flags,
    output logic                 wr_ctrl,
    output logic                 wr_cmpen,
    output logic                 wr_opgt,
    output logic                 wr_start,
    output logic [NUM_SLOTS-1:0] res_rd,
    output logic [NUM_SLOTS-1:0] res_wr
);
    import cfu_pkg::*;

    logic is_res;
    logic is_low;
    logic [ADDR_W-2:0] low_addr;

    // Split the address into bank select and offset.
    always_comb begin
        is_res   = bus_addr[ADDR_W-1];
        is_low   = !bus_addr[ADDR_W-1];
        low_addr = bus_addr[ADDR_W-2:0];
    end

    // Control register write strobes.
    always_comb begin
        wr_flags = bus_sel && bus_wr && is_low && (low_addr == (ADDR_W-1)'(ADDR_FLAGS));
        wr_ctrl  = bus_sel && bus_wr && is_low && (low_addr == (ADDR_W-1)'(ADDR_CTRL));
        wr_cmpen = bus_sel && bus_wr && is_low && (low_addr == (ADDR_W-1)'(ADDR_CMPEN));
        wr_opgt  = bus_sel && bus_wr && is_low && (low_addr == (ADDR_W-1)'(ADDR_OPGT));
        wr_start = bus_sel && bus_wr && is_low && (low_addr == (ADDR_W-1)'(ADDR_START));
    end

    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_res_dec
            // Per-slot result register read and write strobes.
            always_comb begin
                res_rd[g] = bus_sel && !bus_wr && is_res && (low_addr[SLOT_W-1:0] == SLOT_W'(g));
                res_wr[g] = bus_sel &&  bus_wr && is_res && (low_addr[SLOT_W-1:0] == SLOT_W'(g));
            end
        end
    endgenerate

endmodule

// File: rtl/cfu_slot.sv
// Module: one sequence slot - its flag bit and result/threshold register.
// Assumes at most one done strobe per cycle and that hit already
// includes the slot index match.
module cfu_slot #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] conv_value,
    input  logic              cmp_en,
    input  logic              op_gt,
    input  logic              fast_clr,
    input  logic              start_clr,
    input  logic              w1c,
    input  logic              res_rd,
    input  logic              res_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              flag,
    output logic [DATA_W-1:0] result
);
    logic cmp_true;
    logic set_req;
    logic clr_req;

    // Evaluate the compare against the stored threshold.
    always_comb begin
        cmp_true = op_gt ? (conv_value > result) : (conv_value <= result);
    end

    // Decide set and clear requests for this slot.
    always_comb begin
        set_req = hit && (!cmp_en || cmp_true);
        if (fast_clr) begin
            clr_req = cmp_en ? res_wr : res_rd;
        end else begin
            clr_req = w1c;
        end
    end

    // Flag register: start clear beats set, set beats the other clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (start_clr) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // Result register: conversion store in normal mode, else bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (hit && !cmp_en) begin
            result <= conv_value;
        end else if (res_wr) begin
            result <= wdata;
        end
    end

    // R5
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> !flag);

    // R2
    cmp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cmp_en && !res_wr) |=> $stable(result));

    // R1
    normal_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmp_en && !start_clr) |=> (flag && result == $past(conv_value)));

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmp_en && !start_clr && (w1c || res_rd)) |=> flag);

    // R6
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && !fast_clr && !hit && !start_clr) |=> !flag);

endmodule

// File: rtl/cfu_irq.sv
// Module: compare interrupt request from compare-mode flags.
// Assumes flags and enables are registered state; output is combinational.
module cfu_irq #(
    parameter int NUM_SLOTS = 16
) (
    input  logic [NUM_SLOTS-1:0] flags,
    input  logic [NUM_SLOTS-1:0] cmp_en,
    input  logic                 irq_en,
    output logic                 cmp_irq
);
    // Request when any compare-mode flag is up and enabled.
    always_comb begin
        cmp_irq = irq_en && (|(flags & cmp_en));
    end
endmodule

// File: rtl/conv_flag_unit.sv
// Module: conversion slot flag register with per-slot result/threshold
// registers, mode bits, register bus and compare interrupt.
// Assumes NUM_SLOTS is a power of two, DATA_W <= NUM_SLOTS (bus width),
// and one done strobe at most per cycle.
module conv_flag_unit #(
    parameter int NUM_SLOTS = 16,
    parameter int DATA_W    = 10,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = SLOT_W + 1,
    localparam int BUS_W    = NUM_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [SLOT_W-1:0] conv_slot,
    input  logic [DATA_W-1:0] conv_value,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              cmp_irq
);
    import cfu_pkg::*;

    cfu_ctrl_t             ctrl_q;
    logic [NUM_SLOTS-1:0]  cmp_en_q;
    logic [NUM_SLOTS-1:0]  op_gt_q;
    logic [NUM_SLOTS-1:0]  flags;
    logic [DATA_W-1:0]     results [NUM_SLOTS];

    logic                  wr_flags;
    logic                  wr_ctrl;
    logic                  wr_cmpen;
    logic                  wr_opgt;
    logic                  wr_start;
    logic [NUM_SLOTS-1:0]  res_rd;
    logic [NUM_SLOTS-1:0]  res_wr;

    cfu_bus_decode #(
        .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W   (SLOT_W),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .wr_flags(wr_flags),
        .wr_ctrl (wr_ctrl),
        .wr_cmpen(wr_cmpen),
        .wr_opgt (wr_opgt),
        .wr_start(wr_start),
        .res_rd  (res_rd),
        .res_wr  (res_wr)
    );

    // Mode and enable registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cmp_en_q <= '0;
            op_gt_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.fast_clr <= bus_wdata[CTRL_FAST_BIT];
                ctrl_q.irq_en   <= bus_wdata[CTRL_IEN_BIT];
            end
            if (wr_cmpen) cmp_en_q <= bus_wdata;
            if (wr_opgt)  op_gt_q  <= bus_wdata;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
            logic hit_g;
            // Match the done strobe to this slot.
            always_comb hit_g = conv_done && (conv_slot == SLOT_W'(g));

            cfu_slot #(.DATA_W(DATA_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .hit       (hit_g),
                .conv_value(conv_value),
                .cmp_en    (cmp_en_q[g]),
                .op_gt     (op_gt_q[g]),
                .fast_clr  (ctrl_q.fast_clr),
                .start_clr (wr_start),
                .w1c       (wr_flags && bus_wdata[g]),
                .res_rd    (res_rd[g]),
                .res_wr    (res_wr[g]),
                .wdata     (bus_wdata[DATA_W-1:0]),
                .flag      (flags[g]),
                .result    (results[g])
            );
        end
    endgenerate

    cfu_irq #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .flags  (flags),
        .cmp_en (cmp_en_q),
        .irq_en (ctrl_q.irq_en),
        .cmp_irq(cmp_irq)
    );

    // Read data multiplexer, combinational from current state.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1]) begin
            bus_rdata[DATA_W-1:0] = results[bus_addr[SLOT_W-1:0]];
        end else begin
            case (bus_addr[ADDR_W-2:0])
                (ADDR_W-1)'(ADDR_FLAGS): bus_rdata = flags;
                (ADDR_W-1)'(ADDR_CTRL): begin
                    bus_rdata[CTRL_FAST_BIT] = ctrl_q.fast_clr;
                    bus_rdata[CTRL_IEN_BIT]  = ctrl_q.irq_en;
                end
                (ADDR_W-1)'(ADDR_CMPEN): bus_rdata = cmp_en_q;
                (ADDR_W-1)'(ADDR_OPGT):  bus_rdata = op_gt_q;
                default:                 bus_rdata = '0;
            endcase
        end
    end

    // R4
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.irq_en |-> !cmp_irq);

    // R4
    irq_needs_cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq |-> ((flags & cmp_en_q) != '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (flags == '0 && cmp_en_q == '0 && op_gt_q == '0));

endmodule

// File: tb/conv_flag_unit_tb.sv
`timescale 1ns/1ps
module conv_flag_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        d_done = 1'b0;
    logic [3:0]  d_slot = '0;
    logic [9:0]  d_val = '0;
    logic        d_sel = 1'b0;
    logic        d_wr = 1'b0;
    logic [4:0]  d_addr = '0;
    logic [15:0] d_wd = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit        m_flag [16];
    int        m_res  [16];
    bit [15:0] m_cmpen;
    bit [15:0] m_opgt;
    bit        m_fast;
    bit        m_ien;

    always #2 clk = ~clk;

    conv_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .conv_done(d_done), .conv_slot(d_slot), .conv_value(d_val),
        .bus_sel(d_sel), .bus_wr(d_wr), .bus_addr(d_addr), .bus_wdata(d_wd),
        .bus_rdata(rdata), .cmp_irq(irq)
    );

    function automatic int exp_rd(input int a);
        int v = 0;
        if (a >= 16) return m_res[a-16];
        case (a)
            0: for (int i = 0; i < 16; i++) if (m_flag[i]) v |= (1 << i);
            1: v = (m_fast ? 1 : 0) | (m_ien ? 2 : 0);
            2: v = int'(m_cmpen);
            3: v = int'(m_opgt);
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic bit exp_irq();
        bit any = 0;
        for (int i = 0; i < 16; i++) if (m_flag[i] && m_cmpen[i]) any = 1;
        return m_ien && any;
    endfunction

    // model update at each rising edge from the driven inputs
    always @(posedge clk) begin : model
        bit nflag [16];
        int nres  [16];
        bit hit, ct, set, clr, rrd, rwr, w1c, start;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin m_flag[i] = 0; m_res[i] = 0; end
            m_cmpen = 0; m_opgt = 0; m_fast = 0; m_ien = 0;
        end else begin
            start = d_sel && d_wr && d_addr == 4;
            for (int i = 0; i < 16; i++) begin
                hit = d_done && d_slot == 4'(i);
                ct  = m_opgt[i] ? (int'(d_val) > m_res[i]) : (int'(d_val) <= m_res[i]);
                set = hit && (!m_cmpen[i] || ct);
                rrd = d_sel && !d_wr && d_addr == 5'(16 + i);
                rwr = d_sel &&  d_wr && d_addr == 5'(16 + i);
                w1c = d_sel &&  d_wr && d_addr == 0 && d_wd[i];
                clr = m_fast ? (m_cmpen[i] ? rwr : rrd) : w1c;
                nflag[i] = start ? 1'b0 : set ? 1'b1 : clr ? 1'b0 : m_flag[i];
                nres[i]  = (hit && !m_cmpen[i]) ? int'(d_val) : rwr ? int'(d_wd & 16'h03FF) : m_res[i];
            end
            for (int i = 0; i < 16; i++) begin m_flag[i] = nflag[i]; m_res[i] = nres[i]; end
            if (d_sel && d_wr && d_addr == 1) begin m_fast = d_wd[0]; m_ien = d_wd[1]; end
            if (d_sel && d_wr && d_addr == 2) m_cmpen = d_wd;
            if (d_sel && d_wr && d_addr == 3) m_opgt = d_wd;
        end
    end

    // R4: interrupt compared against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (irq !== exp_irq()) begin
                fails++;
                $display("FAIL R4 cmp_irq actual=%0b expected=%0b at %0t", irq, exp_irq(), $time);
            end
        end
    end

    // one cycle of stimulus; optional read-data check before the edge
    task automatic cyc(input bit done, input int slot, input int val,
                       input bit sel, input bit wr, input int addr, input int wd,
                       input string tag);
        int e;
        d_done = done; d_slot = 4'(slot); d_val = 10'(val);
        d_sel = sel; d_wr = wr; d_addr = 5'(addr); d_wd = 16'(wd);
        #1;
        if (sel && !wr) begin
            e = exp_rd(addr);
            checks++;
            if (int'(rdata) !== e) begin
                fails++;
                $display("FAIL %s read addr=0x%0h actual=0x%0h expected=0x%0h", tag, addr, rdata, e);
            end
        end
        @(posedge clk);
        @(negedge clk);
        d_done = 0; d_sel = 0; d_wr = 0;
    endtask

    task automatic rd(input int a, input string tag);
        cyc(0, 0, 0, 1, 0, a, 0, tag);
    endtask
    task automatic wr(input int a, input int v);
        cyc(0, 0, 0, 1, 1, a, v, "wr");
    endtask
    task automatic conv(input int s, input int v);
        cyc(1, s, v, 0, 0, 0, 0, "conv");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        rd(0, "R10"); rd(19, "R10"); rd(1, "R10"); rd(2, "R10");
        // R1 normal store, slot indexing
        conv(3, 'h155); rd(0, "R1"); rd(19, "R1");
        conv(0, 7); conv(15, 1023); rd(0, "R1"); rd(16, "R1"); rd(31, "R1");
        // R11 start reads as zero
        rd(4, "R11");
        // R6 read no clear, write-0 no effect, write-1 clears
        rd(19, "R6"); rd(0, "R6");
        wr(0, 0); rd(0, "R6");
        wr(0, 1 << 3); rd(0, "R6");
        // R2/R3 greater-than compare on slot 5
        wr(21, 100); wr(3, 1 << 5); wr(2, 1 << 5);
        conv(5, 100); rd(0, "R3"); rd(21, "R2");
        conv(5, 101); rd(0, "R3"); rd(21, "R2");
        // R4 enable the interrupt
        wr(1, 2); rd(1, "R4");
        // R3 less-or-equal compare on slot 6
        wr(22, 50); wr(2, (1 << 5) | (1 << 6));
        conv(6, 51); rd(0, "R3");
        conv(6, 50); rd(0, "R3"); rd(22, "R2");
        conv(6, 0); rd(0, "R3");
        // R5 start clears all, and wins over a concurrent set
        wr(4, 0); rd(0, "R5");
        conv(1, 9); rd(0, "R5");
        cyc(1, 1, 9, 1, 1, 4, 0, "R5"); rd(0, "R5");
        // R7 fast clear on: flag writes ignored, result read clears
        wr(1, 3);
        conv(3, 200); wr(0, 'hFFFF); rd(0, "R7");
        rd(19, "R7"); rd(0, "R7");
        // R8 compare slot cleared by writing its threshold
        conv(5, 500); rd(0, "R8");
        wr(21, 600); rd(0, "R8"); rd(21, "R8");
        conv(5, 500); rd(0, "R8");
        // R9 set beats fast-clear read and fast-clear write
        conv(3, 33);
        cyc(1, 3, 34, 1, 0, 19, 0, "R9"); rd(0, "R9");
        cyc(1, 5, 700, 1, 1, 21, 650, "R9"); rd(0, "R9"); rd(21, "R9");
        // R9 set beats write-one clear with fast clear off
        wr(1, 2);
        cyc(1, 2, 5, 1, 1, 0, 1 << 2, "R9"); rd(0, "R9");
        // R10 reset again clears everything
        rst_n = 0; @(negedge clk); rst_n = 1;
        rd(0, "R10"); rd(2, "R10"); rd(1, "R10"); rd(18, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule